// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides the clock it runs on, taken from the oscillator side of a synthesizer loop, by a programmable ratio. It uses the pulse-swallow method. A prescaler divides by either P or P+1. A swallow counter of width 7 bits keeps the prescaler at P+1 for its first A periods. A program counter of width 11 bits then lets it run at P until N prescaler periods have passed in total. One output cycle therefore lasts P·N + A input clocks. P is 64 or 128, chosen by a single select bit.

The prescaler is modelled as a synchronous counter. Its modulus-control line is also brought out as a port. The divided signal `fp` goes high for the last prescaler period of each output cycle and feeds the phase comparator. The programming side writes a pending setting with a one-clock load strobe. The pending setting takes effect only at the next output-cycle boundary, so the output never has a cycle of a mixed or partial length. Correct ratios need 1 ≤ N and A ≤ N.

Top module: `psd_divider`

## Requirements
- R1: While `rst_n` is low, and after it rises, the block holds `fp` = 0 and `mod_hi` = 0. The reset setting is A = 0, N = 2, select = 0. Counting starts on the third rising clock edge after `rst_n` rises, and the first output cycle is 256 clocks long.
- R2: Each output cycle, measured from one falling edge of `fp` to the next, lasts P·N + A input clocks.
- R3: `mod_hi` is 1 for the first A·(P+1) clocks of each output cycle and 0 for the rest of it.
- R4: `fp` is 1 during the final prescaler period of each output cycle and 0 at all other times. That period is P+1 clocks long when A = N and P clocks long otherwise.
- R5: When `cfg_sel64` = 1, P = 64 and the prescaler divides by 64 or 65. When `cfg_sel64` = 0, P = 128 and it divides by 128 or 129.
- R6: A setting loaded during an output cycle does not change the length of that cycle, nor its `mod_hi` or `fp` pattern. It applies from the next cycle onward.
- R7: When A = 0, `mod_hi` stays 0 for the whole cycle, and the cycle is P·N clocks long.
- R8: When A = N, every prescaler period in the cycle is P+1 clocks long, so the cycle is N·(P+1) clocks long.
- R9: If the setting is loaded several times within one output cycle, only the last load before the boundary takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side input clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_load | input | 1 | One-clock strobe that captures the three setting inputs as the pending setting |
| cfg_sel64 | input | 1 | Prescaler pair select: 1 = 64/65, 0 = 128/129 |
| cfg_swallow | input | 7 | Swallow count A |
| cfg_prog | input | 11 | Program count N (at least 1, not below A) |
| mod_hi | output | 1 | Modulus control: 1 while the prescaler divides by P+1 |
| fp | output | 1 | Divided output, high for the last prescaler period of each cycle |

## Verification
Both outputs come from registers. They take their new value on the rising edge at which the reference position moves, and the bench compares them with a behavioural position model at every falling edge that follows. A load strobe applied at a falling edge is captured on the next rising edge. Its effect is due only at the first boundary after that edge, so the model applies the pending values at its own wrap point rather than at the strobe. Cycle lengths are measured between falling edges of `fp` and checked against a queue of cycle totals that the model pushes when it wraps. The model holds its position until the third rising edge after reset release, in step with the internal two-stage reset synchroniser.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned SWALLOW_W = 7;
  localparam int unsigned PROG_W    = 11;
  localparam int unsigned P_SMALL   = 64;
  localparam int unsigned P_LARGE   = 128;
  localparam int unsigned SYNC_LEN  = 2;

  typedef enum logic {
    RATIO_LARGE = 1'b0,
    RATIO_SMALL = 1'b1
  } ratio_sel_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned P_LO = P_SMALL,
  parameter int unsigned P_HI = P_LARGE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ratio_sel_e ratio,
  input  logic       mod_hi,
  output logic       tick
);
  localparam int unsigned PC_W = $clog2(P_HI + 2);
  localparam logic [PC_W-1:0] LAST_LO = PC_W'(P_LO - 1);
  localparam logic [PC_W-1:0] LAST_HI = PC_W'(P_HI - 1);

  logic [PC_W-1:0] pcnt_q, pcnt_d, last_pos;

  always_comb begin
    last_pos = ((ratio == RATIO_SMALL) ? LAST_LO : LAST_HI) + PC_W'(mod_hi);
    tick     = (pcnt_q == last_pos);
    pcnt_d   = tick ? '0 : pcnt_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R5
  pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PC_W'(P_HI));
endmodule

// File: rtl/psd_cfg_hold.sv
module psd_cfg_hold
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = SWALLOW_W,
  parameter int unsigned N_W     = PROG_W,
  parameter int unsigned RST_A   = 0,
  parameter int unsigned RST_N   = 2,
  parameter bit          RST_SEL = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           in_sel,
  input  logic [A_W-1:0] in_a,
  input  logic [N_W-1:0] in_n,
  input  logic           cyc_end,
  output logic [A_W-1:0] pend_a,
  output logic [N_W-1:0] pend_n,
  output ratio_sel_e     act_sel
);
  logic       pend_sel;
  ratio_sel_e act_sel_d;

  always_comb begin
    act_sel_d = act_sel;
    if (cyc_end) act_sel_d = ratio_sel_e'(pend_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a   <= A_W'(RST_A);
      pend_n   <= N_W'(RST_N);
      pend_sel <= RST_SEL;
    end else if (load) begin
      pend_a   <= in_a;
      pend_n   <= in_n;
      pend_sel <= in_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_sel <= ratio_sel_e'(RST_SEL);
    else        act_sel <= act_sel_d;
  end

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(act_sel));
endmodule

// File: rtl/psd_swallow_prog.sv
module psd_swallow_prog
  import psd_pkg::*;
#(
  parameter int unsigned A_W   = SWALLOW_W,
  parameter int unsigned N_W   = PROG_W,
  parameter int unsigned RST_A = 0,
  parameter int unsigned RST_N = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [A_W-1:0] rel_a,
  input  logic [N_W-1:0] rel_n,
  output logic           mod_hi,
  output logic           cyc_end,
  output logic           fp
);
  logic [A_W-1:0] acnt_q, acnt_d;
  logic [N_W-1:0] ncnt_q, ncnt_d;
  logic           fp_d;

  always_comb begin
    cyc_end = tick && (ncnt_q == N_W'(1));
    acnt_d  = acnt_q;
    ncnt_d  = ncnt_q;
    if (cyc_end) begin
      acnt_d = rel_a;
      ncnt_d = rel_n;
    end else if (tick) begin
      ncnt_d = ncnt_q - N_W'(1);
      if (acnt_q != '0) acnt_d = acnt_q - A_W'(1);
    end
    fp_d   = (ncnt_d == N_W'(1));
    mod_hi = (acnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt_q <= A_W'(RST_A);
      ncnt_q <= N_W'(RST_N);
      fp     <= (RST_N == 1);
    end else if (tick) begin
      acnt_q <= acnt_d;
      ncnt_q <= ncnt_d;
      fp     <= fp_d;
    end
  end

  // R3
  mod_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mod_hi));
  // R3
  swallow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cyc_end && acnt_q != '0) |=> acnt_q == $past(acnt_q) - A_W'(1));
  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (ncnt_q == $past(rel_n)) && (acnt_q == $past(rel_a)));
  // R4
  fp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fp) |-> $past(tick));
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = SWALLOW_W,
  parameter int unsigned N_W     = PROG_W,
  parameter int unsigned P_LO    = P_SMALL,
  parameter int unsigned P_HI    = P_LARGE,
  parameter int unsigned SYNC    = SYNC_LEN,
  parameter int unsigned RST_A   = 0,
  parameter int unsigned RST_N   = 2,
  parameter bit          RST_SEL = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic           cfg_sel64,
  input  logic [A_W-1:0] cfg_swallow,
  input  logic [N_W-1:0] cfg_prog,
  output logic           mod_hi,
  output logic           fp
);
  logic [SYNC-1:0] rst_pipe;
  logic            rst_int_n;
  logic            tick, cyc_end;
  logic [A_W-1:0]  pend_a;
  logic [N_W-1:0]  pend_n;
  ratio_sel_e      act_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC-1];

  psd_cfg_hold #(
    .A_W(A_W), .N_W(N_W), .RST_A(RST_A), .RST_N(RST_N), .RST_SEL(RST_SEL)
  ) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .load(cfg_load), .in_sel(cfg_sel64),
    .in_a(cfg_swallow), .in_n(cfg_prog), .cyc_end(cyc_end),
    .pend_a(pend_a), .pend_n(pend_n), .act_sel(act_sel)
  );

  psd_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .ratio(act_sel), .mod_hi(mod_hi), .tick(tick)
  );

  psd_swallow_prog #(
    .A_W(A_W), .N_W(N_W), .RST_A(RST_A), .RST_N(RST_N)
  ) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .rel_a(pend_a), .rel_n(pend_n),
    .mod_hi(mod_hi), .cyc_end(cyc_end), .fp(fp)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!mod_hi && (fp == (RST_N == 1))));
endmodule

// File: tb/psd_divider_test.sv
module psd_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic        cfg_sel64 = 1'b0;
  logic [6:0]  cfg_swallow = '0;
  logic [10:0] cfg_prog = 11'd2;
  logic        mod_hi, fp;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  psd_divider uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sel64(cfg_sel64),
    .cfg_swallow(cfg_swallow), .cfg_prog(cfg_prog), .mod_hi(mod_hi), .fp(fp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: position within the output cycle and settings.
  int pos, rel;
  int a_act, n_act, s_act, a_p, n_p, s_p;
  int tot_q[$];
  string tag_q[$];

  function automatic int pval(input int s);
    return s ? 64 : 128;
  endfunction
  function automatic int total(input int s, input int n, input int a);
    return pval(s) * n + a;
  endfunction
  function automatic int lastlen(input int s, input int n, input int a);
    return (a >= n) ? pval(s) + 1 : pval(s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; pos = 0;
      a_act = 0; n_act = 2; s_act = 0;
      a_p = 0; n_p = 2; s_p = 0;
      tot_q.delete(); tag_q.delete();
    end else if (rel < 2) begin
      rel++;
    end else begin
      if (pos == total(s_act, n_act, a_act) - 1) begin
        tot_q.push_back(total(s_act, n_act, a_act));
        tag_q.push_back(tag);
        a_act = a_p; n_act = n_p; s_act = s_p;
        pos = 0;
      end else begin
        pos++;
      end
      if (cfg_load) begin
        a_p = cfg_swallow; n_p = cfg_prog; s_p = cfg_sel64;
      end
    end
  end

  // Per-cycle comparison and cycle-length measurement.
  bit checking = 0, fp_prev = 0, have_fall = 0;
  int since = 0, wd = 0;
  always @(negedge clk) begin
    wd++;
    if (checking) begin
      bit e_mod, e_fp;
      e_mod = pos < a_act * (pval(s_act) + 1);
      e_fp  = pos >= total(s_act, n_act, a_act) - lastlen(s_act, n_act, a_act);
      check(mod_hi == e_mod, "R3 mod_hi", mod_hi, e_mod);
      check(fp == e_fp, "R4 fp", fp, e_fp);
      since++;
      if (fp_prev && !fp) begin
        int exp_t; string t;
        exp_t = tot_q.size() ? tot_q.pop_front() : -1;
        t = tag_q.size() ? tag_q.pop_front() : "R2";
        if (have_fall) check(since == exp_t, {"R2 length ", t}, since, exp_t);
        have_fall = 1;
        since = 0;
      end
      fp_prev = fp;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input bit s, input int n, input int a);
    @(negedge clk);
    cfg_sel64 = s; cfg_prog = 11'(n); cfg_swallow = 7'(a); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    cycles(5);
    check(fp == 1'b0, "R1 fp in reset", fp, 0);
    check(mod_hi == 1'b0, "R1 mod_hi in reset", mod_hi, 0);
    rst_n = 1'b1;
    checking = 1;
    cycles(600);
    tag = "R5 R2";
    load(1'b1, 5, 3);
    cycles(1100);
    tag = "R5";
    load(1'b0, 3, 1);
    cycles(1300);
    tag = "R7";
    load(1'b1, 4, 0);
    cycles(800);
    tag = "R8";
    load(1'b1, 2, 2);
    cycles(400);
    // R6: load shortly after a boundary; the running cycle must keep 130 clocks
    @(negedge clk);
    while (fp) @(negedge clk);
    cycles(10);
    tag = "R6";
    load(1'b0, 2, 1);
    cycles(700);
    // R9: two loads inside one cycle, the second one wins
    tag = "R9";
    load(1'b1, 3, 2);
    cycles(5);
    load(1'b1, 6, 6);
    cycles(1200);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (wd < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule